// File: doc/BRIEF.md
# Sync-Clocked Display Identification Byte Transmitter

This block streams display identification bytes out of a single data pin, one bit per rising edge of the vertical sync input. Software writes a byte into a holding register and sets the enable bit. The block then sends that byte most significant bit first, followed by a padding bit whose level software chooses. Once the padding bit has gone out, the next byte is copied from the holding register and a transmit interrupt flag is raised, so software can supply the byte after it.

When the enable bit is clear, the data pin is released high and vertical sync is ignored. The block then watches the two-wire clock input instead. A falling edge followed by 16 system clock cycles of continuous low raises a clock-stretch interrupt flag. Both inputs are asynchronous and pass through two-flop synchronizers. The data pin is open-drain style: the block only asserts a pull-low request.

Top module: `edid_vsync_tx`

## Requirements
- R1: After reset, both interrupt flags are 0, the enable bit is 0 and `sdaDriveLow` is 0 (line released high).
- R2: Register writes use `regAddr`. Address 0 is the holding byte. Address 1 is control, with bit 0 the enable bit and bit 1 the padding-bit select. Address 2 is flag clear, with bit 0 for the transmit flag and bit 1 for the clock-stretch flag. When the enable bit goes from 0 to 1, the holding byte is loaded and its bit 7 appears on the line.
- R3: While enabled, each rising edge of `vsyncIn` advances the line to the next data bit, most significant bit first.
- R4: After the eighth data bit, the line carries the padding bit. It is 1 when control bit 1 is set and 0 when it is clear.
- R5: The rising edge that ends the padding bit loads the holding byte into the shift register, puts its bit 7 on the line and sets `txIrq`.
- R6: If the holding byte has not been rewritten since the last load, the same byte is sent again.
- R7: While the enable bit is 0, `sdaDriveLow` is 0 and rising edges of `vsyncIn` set no flag.
- R8: While the enable bit is 0, a falling edge of `sclIn` followed by 16 system clock cycles of low sets `sclIrq`. This happens at most once per low period.
- R9: A low period on `sclIn` shorter than 16 cycles sets nothing. While the enable bit is 1, `sclIn` sets nothing.
- R10: Each flag stays set until a write to address 2 with its bit at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Register write strobe, one cycle per write |
| regAddr | input | 2 | Register address |
| regWrData | input | 8 | Register write data |
| vsyncIn | input | 1 | Vertical sync, used as the shift clock |
| sclIn | input | 1 | Two-wire clock input, watched when disabled |
| sdaDriveLow | output | 1 | 1 pulls the data line low, 0 releases it |
| txIrq | output | 1 | Transmit byte-reload interrupt flag |
| sclIrq | output | 1 | Clock-low-duration interrupt flag |

## Verification
The assertions assume that a flag-clear write is a single-cycle strobe and that the enable bit changes only through register writes. They also assume that synchronized input edges are the only cause of shifting or of clock-stretch detection. The stimulus holds every `vsyncIn` and `sclIn` level for at least four system clocks, so each level passes the synchronizer and no edge is lost. Register writes are driven on the falling clock edge and last exactly one cycle. Every check is sampled several cycles after the edge it depends on.

// File: rtl/edid_tx_pkg.sv
package edid_tx_pkg;
  typedef struct packed {
    logic loadShift;   // copy holding byte into shift register
    logic shiftBit;    // advance to next data bit
    logic ninthPhase;  // line currently carries the padding bit
    logic setTxIrq;    // byte reload event
    logic setSclIrq;   // clock held low long enough
  } ctlStrobes_t;

  localparam logic [1:0] ADDR_HOLD = 2'd0;
  localparam logic [1:0] ADDR_CTRL = 2'd1;
  localparam logic [1:0] ADDR_FLAG = 2'd2;
endpackage

// File: rtl/edid_tx_ctrl.sv
module edid_tx_ctrl
  import edid_tx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int LOW_CYCLES  = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        enableBit,
  input  logic        vsyncIn,
  input  logic        sclIn,
  output ctlStrobes_t strobes
);
  localparam int BIT_CNT_W = $clog2(DATA_W + 1);
  localparam int LOW_CNT_W = $clog2(LOW_CYCLES);
  localparam logic [BIT_CNT_W-1:0] LAST_IDX = BIT_CNT_W'(DATA_W);
  localparam logic [LOW_CNT_W-1:0] LOW_LAST = LOW_CNT_W'(LOW_CYCLES - 1);

  // synchronizer chains plus one history stage for edge detection
  logic [SYNC_STAGES:0] vsyncPipe;
  logic [SYNC_STAGES:0] sclPipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vsyncPipe <= '0;
      sclPipe   <= '1;
    end else begin
      vsyncPipe <= {vsyncPipe[SYNC_STAGES-1:0], vsyncIn};
      sclPipe   <= {sclPipe[SYNC_STAGES-1:0], sclIn};
    end
  end

  logic vsyncRise, sclFall, sclLow;
  assign vsyncRise = vsyncPipe[SYNC_STAGES-1] & ~vsyncPipe[SYNC_STAGES];
  assign sclFall   = ~sclPipe[SYNC_STAGES-1] & sclPipe[SYNC_STAGES];
  assign sclLow    = ~sclPipe[SYNC_STAGES-1];

  // transmit sequencing
  logic                 enPrev;
  logic [BIT_CNT_W-1:0] bitCnt;
  logic                 enRise, unitDone;

  assign enRise   = enableBit & ~enPrev;
  assign unitDone = enableBit & vsyncRise & (bitCnt == LAST_IDX);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enPrev <= 1'b0;
      bitCnt <= '0;
    end else begin
      enPrev <= enableBit;
      if (!enableBit || enRise || unitDone) begin
        bitCnt <= '0;
      end else if (vsyncRise) begin
        bitCnt <= bitCnt + 1'b1;
      end
    end
  end

  // clock-low duration watcher
  logic                 lowActive;
  logic [LOW_CNT_W-1:0] lowCnt;
  logic                 lowHit;

  assign lowHit = ~enableBit & lowActive & sclLow & (lowCnt == LOW_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowActive <= 1'b0;
      lowCnt    <= '0;
    end else if (enableBit) begin
      lowActive <= 1'b0;
      lowCnt    <= '0;
    end else if (sclFall) begin
      lowActive <= 1'b1;
      lowCnt    <= '0;
    end else if (lowActive) begin
      if (!sclLow || lowHit) begin
        lowActive <= 1'b0;
      end else begin
        lowCnt <= lowCnt + 1'b1;
      end
    end
  end

  always_comb begin
    strobes.loadShift  = enRise | unitDone;
    strobes.shiftBit   = enableBit & ~enRise & vsyncRise & (bitCnt < LAST_IDX);
    strobes.ninthPhase = (bitCnt == LAST_IDX);
    strobes.setTxIrq   = unitDone & ~enRise;
    strobes.setSclIrq  = lowHit;
  end
endmodule

// File: rtl/edid_tx_datapath.sv
module edid_tx_datapath
  import edid_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [1:0]        regAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  ctlStrobes_t       strobes,
  output logic              enableBit,
  output logic              sdaDriveLow,
  output logic              txIrq,
  output logic              sclIrq
);
  logic [DATA_W-1:0] holdByte;
  logic [DATA_W-1:0] shiftReg;
  logic              ninthSel;
  logic              wrHold, wrCtrl, wrFlag;

  assign wrHold = regWrEn & (regAddr == ADDR_HOLD);
  assign wrCtrl = regWrEn & (regAddr == ADDR_CTRL);
  assign wrFlag = regWrEn & (regAddr == ADDR_FLAG);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdByte  <= '0;
      enableBit <= 1'b0;
      ninthSel  <= 1'b0;
    end else begin
      if (wrHold) holdByte <= regWrData;
      if (wrCtrl) begin
        enableBit <= regWrData[0];
        ninthSel  <= regWrData[1];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
    end else if (strobes.loadShift) begin
      shiftReg <= holdByte;
    end else if (strobes.shiftBit) begin
      shiftReg <= {shiftReg[DATA_W-2:0], 1'b0};
    end
  end

  // set has priority over a clear in the same cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txIrq  <= 1'b0;
      sclIrq <= 1'b0;
    end else begin
      if (strobes.setTxIrq)            txIrq <= 1'b1;
      else if (wrFlag && regWrData[0]) txIrq <= 1'b0;
      if (strobes.setSclIrq)           sclIrq <= 1'b1;
      else if (wrFlag && regWrData[1]) sclIrq <= 1'b0;
    end
  end

  logic lineBit;
  assign lineBit     = strobes.ninthPhase ? ninthSel : shiftReg[DATA_W-1];
  assign sdaDriveLow = enableBit & ~lineBit;
endmodule

// File: rtl/edid_vsync_tx.sv
module edid_vsync_tx
  import edid_tx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int LOW_CYCLES  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [1:0]        regAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              vsyncIn,
  input  logic              sclIn,
  output logic              sdaDriveLow,
  output logic              txIrq,
  output logic              sclIrq
);
  ctlStrobes_t strobes;
  logic        enableBit;

  edid_tx_ctrl #(
    .DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES), .LOW_CYCLES(LOW_CYCLES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .enableBit(enableBit),
    .vsyncIn(vsyncIn), .sclIn(sclIn), .strobes(strobes)
  );

  edid_tx_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .strobes(strobes), .enableBit(enableBit),
    .sdaDriveLow(sdaDriveLow), .txIrq(txIrq), .sclIrq(sclIrq)
  );
endmodule

// File: rtl/edid_vsync_tx_checker.sv
module edid_vsync_tx_checker (
  input logic clk,
  input logic rstN,
  input logic enableBit,
  input logic sdaDriveLow,
  input logic txIrq,
  input logic sclIrq,
  input logic clrTxReq,
  input logic clrSclReq
);
  assert_released_when_off_R7: assert property (@(posedge clk) disable iff (!rstN)
    !enableBit |-> !sdaDriveLow);

  assert_tx_flag_only_enabled_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txIrq) |-> $past(enableBit));

  assert_scl_flag_only_disabled_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sclIrq) |-> !$past(enableBit));

  assert_tx_sticky_R10: assert property (@(posedge clk) disable iff (!rstN)
    (txIrq && !clrTxReq) |=> txIrq);

  assert_scl_sticky_R10: assert property (@(posedge clk) disable iff (!rstN)
    (sclIrq && !clrSclReq) |=> sclIrq);
endmodule

bind edid_vsync_tx edid_vsync_tx_checker u_chk (
  .clk(clk), .rstN(rstN), .enableBit(enableBit), .sdaDriveLow(sdaDriveLow),
  .txIrq(txIrq), .sclIrq(sclIrq),
  .clrTxReq(regWrEn && (regAddr == 2'd2) && regWrData[0]),
  .clrSclReq(regWrEn && (regAddr == 2'd2) && regWrData[1])
);

// File: tb/edid_vsync_tx_bench.sv
module edid_vsync_tx_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWrEn = 1'b0;
  logic [1:0] regAddr = '0;
  logic [7:0] regWrData = '0;
  logic       vsyncIn = 1'b0;
  logic       sclIn = 1'b1;
  logic       sdaDriveLow, txIrq, sclIrq;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  typedef struct { logic lineLevel; string req; } expItem_t;
  expItem_t expQ[$];
  event sampleEv;

  always #5 clk = ~clk;

  edid_vsync_tx u_edid_vsync_tx (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .vsyncIn(vsyncIn), .sclIn(sclIn),
    .sdaDriveLow(sdaDriveLow), .txIrq(txIrq), .sclIrq(sclIrq)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: line level is released-high unless pull-low requested
  initial begin
    forever begin
      @(sampleEv);
      if (expQ.size() > 0) begin
        expItem_t it;
        it = expQ.pop_front();
        check(it.req, {31'd0, ~sdaDriveLow}, {31'd0, it.lineLevel});
      end
    end
  end

  task automatic regWrite(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic expectLine(logic lvl, string req);
    expItem_t it;
    it.lineLevel = lvl; it.req = req;
    expQ.push_back(it);
    -> sampleEv;
    #1;
  endtask

  task automatic vsyncPulse();
    @(negedge clk); vsyncIn = 1'b1;
    repeat (4) @(negedge clk);
    vsyncIn = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  // drive a pulse and push the level the line should then show
  task automatic pulseExpect(logic lvl, string req);
    vsyncPulse();
    expectLine(lvl, req);
  endtask

  task automatic sclLowFor(int n);
    @(negedge clk); sclIn = 1'b0;
    repeat (n) @(negedge clk);
    sclIn = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] byteA;
    logic [7:0] byteB;
    byteA = 8'hA5;
    byteB = 8'h3C;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 txIrq", {31'd0, txIrq}, 0);
    check("R1 sclIrq", {31'd0, sclIrq}, 0);
    check("R1 line", {31'd0, sdaDriveLow}, 0);

    regWrite(2'd0, byteA);
    regWrite(2'd1, 8'h03);            // enable, padding bit 1
    expectLine(byteA[7], "R2 first bit");
    for (int k = 6; k >= 0; k--) pulseExpect(byteA[k], "R3 data bit");
    pulseExpect(1'b1, "R4 padding one");
    regWrite(2'd0, byteB);
    check("R5 no early flag", {31'd0, txIrq}, 0);
    pulseExpect(byteB[7], "R5 reload bit7");
    check("R5 txIrq set", {31'd0, txIrq}, 1);
    repeat (10) @(negedge clk);
    check("R10 txIrq held", {31'd0, txIrq}, 1);
    regWrite(2'd2, 8'h01);
    check("R10 txIrq cleared", {31'd0, txIrq}, 0);

    regWrite(2'd1, 8'h01);            // padding bit 0
    for (int k = 6; k >= 0; k--) pulseExpect(byteB[k], "R3 data bit");
    pulseExpect(1'b0, "R4 padding zero");
    pulseExpect(byteB[7], "R6 resend bit7");
    pulseExpect(byteB[6], "R6 resend bit6");
    pulseExpect(byteB[5], "R6 resend bit5");
    regWrite(2'd2, 8'h01);

    regWrite(2'd1, 8'h00);            // disable
    expectLine(1'b1, "R7 released");
    for (int k = 0; k < 10; k++) vsyncPulse();
    check("R7 no txIrq", {31'd0, txIrq}, 0);
    check("R7 line high", {31'd0, sdaDriveLow}, 0);

    sclLowFor(8);
    repeat (20) @(negedge clk);
    check("R9 short low", {31'd0, sclIrq}, 0);
    @(negedge clk); sclIn = 1'b0;
    repeat (30) @(negedge clk);
    check("R8 long low", {31'd0, sclIrq}, 1);
    regWrite(2'd2, 8'h02);
    repeat (30) @(negedge clk);
    check("R8 once per low", {31'd0, sclIrq}, 0);
    sclIn = 1'b1;
    repeat (6) @(negedge clk);

    regWrite(2'd1, 8'h01);            // enabled: clock ignored
    sclLowFor(40);
    repeat (10) @(negedge clk);
    check("R9 enabled ignores scl", {31'd0, sclIrq}, 0);
    check("R2 reenable bit7", {31'd0, ~sdaDriveLow}, {31'd0, byteB[7]});

    repeat (4) @(negedge clk);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule